// File: doc/BRIEF.md
# Interrupt Completion and Deactivation Unit

This block holds the completion state of a single CPU interface in an interrupt controller. Each interrupt has an active bit, and a short stack of running priorities records the nesting of interrupts in service. An acknowledge input, driven by logic outside this block, marks an interrupt active and pushes its priority. Software then retires the interrupt through register writes on a small memory-mapped write port. Every write carries a secure/non-secure attribute.

Completion works in one of two ways. In combined mode, an end-of-interrupt write drops the running priority and clears the active bit in the same step. In split mode, the end-of-interrupt write only drops the priority, and a later write to a separate deactivate register clears the active bit. Split mode exists only in the revision-2 build. When the security extension is present, a non-secure access uses its own mode bit. The block outputs the active bits, the current running priority, and a one-cycle flag for writes it does not recognise.

Top module: `irq_complete_unit`

## Requirements
- R1: After reset, all active bits are 0, the running priority reads 0xFF, and both completion-mode bits are 0, so the first end-of-interrupt write runs in combined mode.
- R2: The control register is at offset 0x000. A secure write loads bit 0 into the secure mode bit and bit 1 into the non-secure mode bit. With the security extension present, a non-secure write loads only the non-secure mode bit, taken from data bit 0.
- R3: Split mode is in force only when REVISION equals 2. With the security extension present, a non-secure access uses the non-secure mode bit. Every other access uses the secure mode bit.
- R4: An acknowledge pulse (act_valid) sets the active bit of act_id and pushes act_prio. The running priority is then the most recently pushed value.
- R5: An end-of-interrupt write (offset 0x004, identifier in data[9:0]) always pops the top priority. It clears the identifier's active bit only when split mode is off.
- R6: A deactivate write is at offset 0x1000 and uses only data[9:0] as the identifier. When accepted, it clears that active bit and leaves the running priority unchanged.
- R7: A deactivate write while split mode is off changes no state.
- R8: With the security extension present, a non-secure deactivate of a group-0 interrupt is ignored. grp_bits bit n = 1 puts interrupt n in group 1. A build without grouping treats every interrupt as group 0.
- R9: Some writes are ignored and raise bad_access_o for exactly one cycle, in the cycle after the write: any offset other than 0x000 or 0x004, or 0x1000 on revision 2, and any offset at or beyond the decode window (0x2000 on revision 2, 0x100 otherwise).
- R10: Identifiers at or above NUM_IRQ touch no active bit. An end-of-interrupt write with such an identifier still pops the priority.
- R11: With an empty priority stack, the running priority reads 0xFF, and an end-of-interrupt write leaves it at 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset within the CPU interface |
| wr_data | input | 32 | Write data |
| wr_secure | input | 1 | 1 = secure access |
| act_valid | input | 1 | Acknowledge pulse from the arbitration logic |
| act_id | input | 10 | Identifier being acknowledged |
| act_prio | input | PRIO_W | Priority of the acknowledged interrupt |
| grp_bits | input | NUM_IRQ | Group of each interrupt (1 = group 1) |
| active_o | output | NUM_IRQ | Active bit per interrupt |
| run_prio_o | output | PRIO_W | Running priority, all ones when idle |
| bad_access_o | output | 1 | One-cycle flag for an unrecognised write |

## Verification
The assertions assume that an acknowledge and a register write never fall in the same cycle. They also assume that acknowledges never exceed the stack depth, and that each new acknowledge carries a priority at least as urgent as the one already running. Under these assumptions, a change to the active bits or the running priority can always be traced to a single write. The directed tasks keep to these limits: every write and every acknowledge is a separate two-edge transaction, and no scenario nests more than three interrupts. Each scenario starts from a fresh reset.

// File: rtl/icu_pkg.sv
// Shared decode types and register offsets for the completion unit.
package icu_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_CTRL,
        OP_EOI,
        OP_DIR,
        OP_BAD
    } icu_op_e;

    localparam int ID_W     = 10;
    localparam int OFF_CTRL = 'h0000;
    localparam int OFF_EOI  = 'h0004;
    localparam int OFF_DIR  = 'h1000;
endpackage

// File: rtl/icu_decode.sv
// Address decoder: sorts a write into control, end-of-interrupt, deactivate
// or bad. Assumes the address is a byte offset from the interface base.
module icu_decode #(
    parameter int ADDR_W   = 16,
    parameter int REVISION = 2
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    output icu_pkg::icu_op_e  op
);
    import icu_pkg::*;

    localparam int WINDOW = (REVISION == 2) ? 'h2000 : 'h100;
    localparam bit HAS_DIR = (REVISION == 2);

    // Classify the current write by offset and window.
    always_comb begin
        op = OP_NONE;
        if (wr_valid) begin
            if (int'(wr_addr) >= WINDOW)
                op = OP_BAD;
            else if (int'(wr_addr) == OFF_CTRL)
                op = OP_CTRL;
            else if (int'(wr_addr) == OFF_EOI)
                op = OP_EOI;
            else if (HAS_DIR && int'(wr_addr) == OFF_DIR)
                op = OP_DIR;
            else
                op = OP_BAD;
        end
    end
endmodule

// File: rtl/icu_prio_stack.sv
// Running-priority stack: push on acknowledge, pop on end-of-interrupt.
// Assumes pushes never exceed DEPTH; pushes when full and pops when empty are dropped.
module icu_prio_stack #(
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PRIO_W-1:0] slot [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic              full;

    assign full  = (int'(cnt) == DEPTH);
    assign empty = (cnt == '0);

    // Occupancy and slot update for push, pop or both at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= '1;
        end else if (push && pop && !empty) begin
            slot[int'(cnt) - 1] <= push_prio;
        end else if (push && !full) begin
            slot[int'(cnt)] <= push_prio;
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Top of stack, or idle value when empty.
    always_comb begin
        top_prio = '1;
        if (!empty) top_prio = slot[int'(cnt) - 1];
    end
endmodule

// File: rtl/icu_active_bank.sv
// Per-interrupt active flags. When a set and a clear hit the same bit,
// the set wins. Identifiers outside the bank match no bit.
module icu_active_bank #(
    parameter int NUM_IRQ = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_valid,
    input  logic [icu_pkg::ID_W-1:0] set_id,
    input  logic                     clr_valid,
    input  logic [icu_pkg::ID_W-1:0] clr_id,
    output logic [NUM_IRQ-1:0]       active
);
    import icu_pkg::*;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
        logic hit_set, hit_clr;
        assign hit_set = set_valid && (set_id == ID_W'(g));
        assign hit_clr = clr_valid && (clr_id == ID_W'(g));

        // One active flag: set has precedence over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       active[g] <= 1'b0;
            else if (hit_set) active[g] <= 1'b1;
            else if (hit_clr) active[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_complete_unit.sv
// Completion side of one CPU interface. Holds the mode bits, picks combined
// or split completion for each access, and applies the deactivate rules.
// Assumes acknowledge and register writes never collide in one cycle.
module irq_complete_unit #(
    parameter int NUM_IRQ    = 32,
    parameter int PRIO_W     = 8,
    parameter int DEPTH      = 4,
    parameter int ADDR_W     = 16,
    parameter int REVISION   = 2,
    parameter bit SEC_EXT    = 1'b1,
    parameter bit HAS_GROUPS = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               wr_secure,
    input  logic               act_valid,
    input  logic [9:0]         act_id,
    input  logic [PRIO_W-1:0]  act_prio,
    input  logic [NUM_IRQ-1:0] grp_bits,
    output logic [NUM_IRQ-1:0] active_o,
    output logic [PRIO_W-1:0]  run_prio_o,
    output logic               bad_access_o
);
    import icu_pkg::*;

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    icu_op_e         op;
    logic [ID_W-1:0] wr_id;
    logic            mode_s, mode_ns;
    logic            split_eff;
    logic            id_grp1;
    logic            dir_ok;
    logic            clr_valid;
    logic            stk_empty;

    assign wr_id = wr_data[ID_W-1:0];

    icu_decode #(.ADDR_W(ADDR_W), .REVISION(REVISION)) u_dec (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .op       (op)
    );

    // Select the mode bit that governs this access.
    always_comb begin
        split_eff = 1'b0;
        if (REVISION == 2)
            split_eff = (SEC_EXT && !wr_secure) ? mode_ns : mode_s;
    end

    // Group of the addressed interrupt; group 0 without grouping or when out of range.
    always_comb begin
        id_grp1 = 1'b0;
        if (HAS_GROUPS && int'(wr_id) < NUM_IRQ)
            id_grp1 = grp_bits[wr_id[IDX_W-1:0]];
    end

    // Deactivate acceptance and the combined active-clear request.
    assign dir_ok    = (op == OP_DIR) && split_eff && !(SEC_EXT && !wr_secure && !id_grp1);
    assign clr_valid = ((op == OP_EOI) && !split_eff) || dir_ok;

    // Mode bits written through the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_s  <= 1'b0;
            mode_ns <= 1'b0;
        end else if (op == OP_CTRL) begin
            if (SEC_EXT && !wr_secure) begin
                mode_ns <= wr_data[0];
            end else begin
                mode_s <= wr_data[0];
                if (SEC_EXT) mode_ns <= wr_data[1];
            end
        end
    end

    // Registered one-cycle flag for an unrecognised write.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_access_o <= 1'b0;
        else        bad_access_o <= (op == OP_BAD);
    end

    icu_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (act_valid),
        .push_prio (act_prio),
        .pop       (op == OP_EOI),
        .top_prio  (run_prio_o),
        .empty     (stk_empty)
    );

    icu_active_bank #(.NUM_IRQ(NUM_IRQ)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (act_valid),
        .set_id    (act_id),
        .clr_valid (clr_valid),
        .clr_id    (wr_id),
        .active    (active_o)
    );
endmodule

// File: rtl/icu_checker.sv
// Temporal checks on the completion unit, bound to every instance.
module icu_checker #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid,
    input icu_pkg::icu_op_e   op,
    input logic               split_eff,
    input logic [9:0]         wr_id,
    input logic               act_valid,
    input logic [NUM_IRQ-1:0] active_o,
    input logic [PRIO_W-1:0]  run_prio_o,
    input logic               stk_empty,
    input logic               bad_access_o
);
    import icu_pkg::*;

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic             eoi_clr_q;
    logic [IDX_W-1:0] eoi_idx_q;

    // Remember a combined end-of-interrupt that must clear a bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_clr_q <= 1'b0;
            eoi_idx_q <= '0;
        end else begin
            eoi_clr_q <= (op == OP_EOI) && !split_eff && !act_valid && (int'(wr_id) < NUM_IRQ);
            eoi_idx_q <= wr_id[IDX_W-1:0];
        end
    end

    assert_eoi_combined_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_clr_q |-> !active_o[eoi_idx_q]);

    assert_dir_keeps_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DIR) && !act_valid |=> $stable(run_prio_o));

    assert_dir_off_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DIR) && !split_eff && !act_valid |=> $stable(active_o));

    assert_bad_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access_o |-> $past(wr_valid));

    assert_idle_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_empty |-> (run_prio_o == {PRIO_W{1'b1}}));
endmodule

bind irq_complete_unit icu_checker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .op           (op),
    .split_eff    (split_eff),
    .wr_id        (wr_id),
    .act_valid    (act_valid),
    .active_o     (active_o),
    .run_prio_o   (run_prio_o),
    .stk_empty    (stk_empty),
    .bad_access_o (bad_access_o)
);

// File: tb/tb_irq_complete_unit.sv
module tb_irq_complete_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_valid = 1'b0;
    logic [15:0]        wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic               wr_secure = 1'b1;
    logic               act_valid = 1'b0;
    logic [9:0]         act_id = '0;
    logic [7:0]         act_prio = '0;
    logic [NUM_IRQ-1:0] grp_bits = 32'hFFFF_0000;
    logic [NUM_IRQ-1:0] active_o;
    logic [7:0]         run_prio_o;
    logic               bad_access_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_complete_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_secure(wr_secure), .act_valid(act_valid),
        .act_id(act_id), .act_prio(act_prio), .grp_bits(grp_bits),
        .active_o(active_o), .run_prio_o(run_prio_o), .bad_access_o(bad_access_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ack(int id, int prio);
        @(negedge clk);
        act_valid = 1'b1; act_id = 10'(id); act_prio = 8'(prio);
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic wr(int addr, logic [31:0] data, bit sec);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 16'(addr); wr_data = data; wr_secure = sec;
        @(negedge clk);
        wr_valid = 1'b0; wr_secure = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 active", active_o, 0);
        check("R1 prio", 32'(run_prio_o), 32'hFF);
        check("R1 bad", 32'(bad_access_o), 0);
        ack(6, 'h50);
        wr('h004, 6, 1'b1);
        check("R1 combined after reset", 32'(active_o[6]), 0);
    endtask

    task automatic t_combined();
        do_reset();
        ack(3, 'h80);
        ack(7, 'h20);
        check("R4 active", active_o, 32'h88);
        check("R4 prio", 32'(run_prio_o), 32'h20);
        wr('h004, 7, 1'b1);
        check("R5 combined clear", active_o, 32'h08);
        check("R5 pop", 32'(run_prio_o), 32'h80);
        wr('h004, 3, 1'b1);
        check("R5 pop to idle", 32'(run_prio_o), 32'hFF);
    endtask

    task automatic t_split_secure();
        do_reset();
        wr('h000, 1, 1'b1);
        ack(9, 'h30);
        wr('h004, 9, 1'b1);
        check("R5 split keeps active", 32'(active_o[9]), 1);
        check("R5 split pops", 32'(run_prio_o), 32'hFF);
        ack(2, 'h40);
        wr('h1000, 32'hFFFF_FC09, 1'b1);
        check("R6 dir upper bits ignored", 32'(active_o[9]), 0);
        check("R6 dir keeps prio", 32'(run_prio_o), 32'h40);
    endtask

    task automatic t_split_ns();
        do_reset();
        wr('h000, 1, 1'b1);
        ack(20, 'h30);
        wr('h004, 20, 1'b0);
        check("R3 ns uses ns bit", 32'(active_o[20]), 0);
        wr('h000, 2, 1'b0);
        ack(21, 'h30);
        wr('h004, 21, 1'b0);
        check("R2 ns write bit1 no effect", 32'(active_o[21]), 0);
        wr('h000, 1, 1'b0);
        ack(22, 'h30);
        wr('h004, 22, 1'b0);
        check("R2 ns write bit0", 32'(active_o[22]), 1);
        ack(4, 'h20);
        wr('h004, 4, 1'b0);
        wr('h1000, 4, 1'b0);
        check("R8 ns dir group0 ignored", 32'(active_o[4]), 1);
        wr('h1000, 22, 1'b0);
        check("R8 ns dir group1", 32'(active_o[22]), 0);
        wr('h1000, 4, 1'b1);
        check("R3 secure dir group0", 32'(active_o[4]), 0);
    endtask

    task automatic t_secure_ctrl_bit1();
        do_reset();
        wr('h000, 2, 1'b1);
        ack(17, 'h30);
        wr('h004, 17, 1'b1);
        check("R2 secure mode still off", 32'(active_o[17]), 0);
        ack(18, 'h30);
        wr('h004, 18, 1'b0);
        check("R2 secure write sets ns bit", 32'(active_o[18]), 1);
    endtask

    task automatic t_dir_off();
        do_reset();
        ack(5, 'h60);
        wr('h1000, 5, 1'b1);
        check("R7 active kept", active_o, 32'h20);
        check("R7 prio kept", 32'(run_prio_o), 32'h60);
    endtask

    task automatic t_bad();
        do_reset();
        ack(1, 'h10);
        wr('h008, 1, 1'b1);
        check("R9 bad pulse", 32'(bad_access_o), 1);
        @(negedge clk);
        check("R9 bad one cycle", 32'(bad_access_o), 0);
        wr('h1800, 1, 1'b1);
        check("R9 in-window undefined", 32'(bad_access_o), 1);
        wr('h2004, 1, 1'b1);
        check("R9 out of window", 32'(bad_access_o), 1);
        check("R9 state kept", active_o, 32'h2);
        check("R9 prio kept", 32'(run_prio_o), 32'h10);
        wr('h004, 1, 1'b1);
        check("R9 good write no flag", 32'(bad_access_o), 0);
    endtask

    task automatic t_range();
        do_reset();
        ack(40, 'h70);
        check("R10 ack out of range", active_o, 0);
        ack(8, 'h50);
        wr('h004, 40, 1'b1);
        check("R10 eoi pops", 32'(run_prio_o), 32'h70);
        check("R10 no bit cleared", active_o, 32'h100);
        wr('h004, 8, 1'b1);
        wr('h004, 8, 1'b1);
        check("R11 empty pop idle", 32'(run_prio_o), 32'hFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_combined();
        t_split_secure();
        t_split_ns();
        t_secure_ctrl_bit1();
        t_dir_off();
        t_bad();
        t_range();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule